// File: doc/BRIEF.md
# Multi-Queue Register Mailbox

This block lets several processors pass fixed-size messages to each other through a 32-bit register bus. It holds a set of independent first-in first-out queues. Each message is sixteen 32-bit words. A producer writes the words of a message one register at a time into a per-queue assembly buffer. Writing the last data register of the queue window pushes the whole message into the queue.

A consumer can look at the words of the oldest message without disturbing it. Reading the last data register returns that word and also removes the message. The number of waiting messages is reported in a separate status word for each queue. Each queue raises a level interrupt for as long as it holds at least one message.

The bus address space has two parts:
- **Data windows.** Every queue appears in one data window per proxy. All proxy windows alias the same queues.
- **Status words.** These sit in a separate region selected by the top address bit.

The queue count, the depth of each queue and the proxy count are parameters.

Top module: `msgq_top`

## Requirements
- R1: After reset, every queue is empty, every interrupt is low, and status and data reads return zero. The bus accepts requests (`req_ready` high) whenever reset is not asserted.
- R2: With the top address bit clear, the data register at index r (16..31) of queue q through proxy p has byte address p·0x10000 + q·0x80 + 4·r. Every proxy window reaches the same queue contents.
- R3: A write to register 31 pushes the assembled message (the buffered words 16..30 plus the written word as word 31) onto the tail of the queue. The count in status bits 23:12 then rises by one.
- R4: A read of register 31 returns word 31 of the head message and removes that message. Messages leave each queue in the order they were pushed.
- R5: Reads of registers 16..30 return the matching word of the head message and change neither the queue contents nor the count.
- R6: The assembly buffer is cleared after every push attempt. Words not written since the previous push read back as zero in the next message.
- R7: A push to a queue already holding DEPTH messages is discarded and sets a sticky overflow flag in status bit 0. Writing the status word with bit 0 set clears the flag. The count never exceeds DEPTH.
- R8: A read of register 31 on an empty queue returns zero and leaves the count at zero.
- R9: `irq[q]` is high exactly while queue q holds at least one message. It rises only after a push and falls only after a pop.
- R10: Certain offsets are undefined: registers 0..15, a nonzero byte offset within a word, queue or proxy fields beyond the configured counts, and nonzero bits above the queue field. Reads of them return zero and writes to them change nothing.
- R11: An accepted read produces `rsp_valid` with its data exactly one cycle later. Writes produce no response.
- R12: Accesses to one queue leave the contents, counts and interrupts of every other queue unchanged.
- R13: With the top address bit set, the status word of queue q sits at byte offset 4·q. Its layout is zeros except for the count in bits 23:12 and the overflow flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17+proxy bits (18 by default) | Byte address; top bit selects the status region |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rsp_rdata | output | 32 | Read data |
| irq | output | NUM_Q | Per-queue message-pending interrupt |

## Verification
A push and the visibility of its effect fall in adjacent cycles. So do a pop and the fall of the interrupt that it causes. The bench provokes both with back-to-back requests: a commit, then at once a status read, then a pop, then another status read. It checks that each read response reflects every earlier access, and that the interrupt drops in the same cycle as the popped word appears on `rsp_rdata`. A behavioural queue model, advanced on every rising edge, judges each response and the interrupt vector every clock. Explicit checks with hand-derived values back up the model.

// File: rtl/msgq_pkg.sv
package msgq_pkg;

    localparam int MSG_WORDS   = 16;
    localparam int WIDX_W      = 4;
    localparam int PROXY_SHIFT = 16;
    localparam int QUEUE_SHIFT = 7;
    localparam int CNT_LSB     = 12;
    localparam int CNT_FIELD_W = 12;
    localparam int OVF_BIT     = 0;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_DATA = 2'd1,
        ACC_STAT = 2'd2
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e         kind;
        logic [7:0]        qidx;
        logic [WIDX_W-1:0] widx;
    } acc_dec_t;

    function automatic int addr_w(input int nproxy);
        return PROXY_SHIFT + 1 + ((nproxy > 1) ? $clog2(nproxy) : 1);
    endfunction

    function automatic logic [31:0] stat_word(input logic [CNT_FIELD_W-1:0] cnt,
                                              input logic ovf);
        logic [31:0] w;
        w = '0;
        w[CNT_LSB +: CNT_FIELD_W] = cnt;
        w[OVF_BIT] = ovf;
        return w;
    endfunction

endpackage

// File: rtl/msgq_decode.sv
module msgq_decode
    import msgq_pkg::*;
#(
    parameter int NUM_Q     = 8,
    parameter int NUM_PROXY = 2
) (
    input  logic [addr_w(NUM_PROXY)-1:0] addr,
    output acc_dec_t                     dec
);
    localparam int AW = addr_w(NUM_PROXY);
    localparam int QB = $clog2(NUM_Q);
    localparam int PB = AW - PROXY_SHIFT - 1;

    logic [QB-1:0] dq;
    logic [QB-1:0] sq;
    logic [PB-1:0] px;
    logic [4:0]    ridx;
    logic          data_ok;
    logic          stat_ok;

    always_comb begin
        dq   = addr[QUEUE_SHIFT +: QB];
        sq   = addr[2 +: QB];
        px   = addr[PROXY_SHIFT +: PB];
        ridx = addr[6:2];

        data_ok = !addr[AW-1]
               && (addr[1:0] == 2'b00)
               && (int'(px) < NUM_PROXY)
               && ((addr[PROXY_SHIFT-1:0] >> (QUEUE_SHIFT + QB)) == '0)
               && (int'(dq) < NUM_Q)
               && ridx[4];

        stat_ok = addr[AW-1]
               && (addr[1:0] == 2'b00)
               && ((addr[AW-2:0] >> (2 + QB)) == '0)
               && (int'(sq) < NUM_Q);

        dec = '0;
        if (data_ok) begin
            dec.kind = ACC_DATA;
            dec.qidx = 8'(dq);
            dec.widx = ridx[3:0];
        end else if (stat_ok) begin
            dec.kind = ACC_STAT;
            dec.qidx = 8'(sq);
        end
    end

endmodule

// File: rtl/msgq_queue.sv
module msgq_queue
    import msgq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic                           rd_en,
    input  logic                           clr_ovf,
    input  logic [WIDX_W-1:0]              widx,
    input  logic [31:0]                    wdata,
    output logic [31:0]                    rword,
    output logic [$clog2(DEPTH+1)-1:0]     cnt,
    output logic                           ovf,
    output logic                           irq
);
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW   = $clog2(DEPTH + 1);
    localparam int LAST = MSG_WORDS - 1;

    logic [31:0]   mem   [DEPTH][MSG_WORDS];
    logic [31:0]   stage [MSG_WORDS];
    logic [PW-1:0] head;
    logic [PW-1:0] tail;
    logic          is_last;
    logic          full;
    logic          empty;
    logic          push_ok;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign is_last = (widx == WIDX_W'(LAST));
    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign push_ok = wr_en && is_last && !full;
    assign irq     = !empty;
    assign rword   = empty ? 32'h0 : mem[head][widx];

    always_ff @(posedge clk) begin
        if (rst) begin
            head <= '0;
            tail <= '0;
            cnt  <= '0;
            ovf  <= 1'b0;
            for (int w = 0; w < MSG_WORDS; w++) stage[w] <= '0;
        end else begin
            if (wr_en) begin
                if (!is_last) begin
                    stage[widx] <= wdata;
                end else begin
                    for (int w = 0; w < MSG_WORDS; w++) stage[w] <= '0;
                    if (!full) begin
                        tail <= ptr_next(tail);
                        cnt  <= cnt + 1'b1;
                    end else begin
                        ovf <= 1'b1;
                    end
                end
            end
            if (rd_en && is_last && !empty) begin
                head <= ptr_next(head);
                cnt  <= cnt - 1'b1;
            end
            if (clr_ovf) ovf <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            for (int w = 0; w < MSG_WORDS; w++)
                mem[tail][w] <= (w == LAST) ? wdata : stage[w];
        end
    end

endmodule

// File: rtl/msgq_rsp.sv
module msgq_rsp (
    input  logic        clk,
    input  logic        rst,
    input  logic        rd_fire,
    input  logic [31:0] rd_val,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_fire;
            if (rd_fire) rsp_rdata <= rd_val;
        end
    end
endmodule

// File: rtl/msgq_top.sv
module msgq_top
    import msgq_pkg::*;
#(
    parameter int NUM_Q     = 8,
    parameter int DEPTH     = 4,
    parameter int NUM_PROXY = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic                         req_write,
    input  logic [addr_w(NUM_PROXY)-1:0] req_addr,
    input  logic [31:0]                  req_wdata,
    output logic                         rsp_valid,
    output logic [31:0]                  rsp_rdata,
    output logic [NUM_Q-1:0]             irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    acc_dec_t          dec;
    logic              fire;
    logic              rd_fire;
    logic [31:0]       rd_val;
    logic [31:0]       qword [NUM_Q];
    logic [CNT_W-1:0]  qcnt  [NUM_Q];
    logic [NUM_Q-1:0]  q_ovf;
    logic [NUM_Q*CNT_W-1:0] q_cnt_flat;

    assign req_ready = !rst;
    assign fire      = req_valid && req_ready;
    assign rd_fire   = fire && !req_write;

    msgq_decode #(.NUM_Q(NUM_Q), .NUM_PROXY(NUM_PROXY)) u_dec (
        .addr (req_addr),
        .dec  (dec)
    );

    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        logic hit;
        assign hit = (dec.qidx == 8'(q));

        msgq_queue #(.DEPTH(DEPTH)) u_queue (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (fire && req_write && hit && (dec.kind == ACC_DATA)),
            .rd_en   (rd_fire && hit && (dec.kind == ACC_DATA)),
            .clr_ovf (fire && req_write && hit && (dec.kind == ACC_STAT) && req_wdata[OVF_BIT]),
            .widx    (dec.widx),
            .wdata   (req_wdata),
            .rword   (qword[q]),
            .cnt     (qcnt[q]),
            .ovf     (q_ovf[q]),
            .irq     (irq[q])
        );

        assign q_cnt_flat[q*CNT_W +: CNT_W] = qcnt[q];
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_Q; i++) begin
            if (dec.qidx == 8'(i)) begin
                if (dec.kind == ACC_DATA)
                    rd_val = qword[i];
                else if (dec.kind == ACC_STAT)
                    rd_val = stat_word(CNT_FIELD_W'(qcnt[i]), q_ovf[i]);
            end
        end
    end

    msgq_rsp u_rsp (
        .clk       (clk),
        .rst       (rst),
        .rd_fire   (rd_fire),
        .rd_val    (rd_val),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

endmodule

// File: rtl/msgq_chk.sv
module msgq_chk #(
    parameter int NUM_Q = 8,
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic                req_ready,
    input logic                req_write,
    input logic                rsp_valid,
    input logic [NUM_Q-1:0]    irq,
    input logic [NUM_Q*CW-1:0] q_cnt_flat,
    input logic [NUM_Q-1:0]    q_ovf
);
    logic acc_rd;
    logic acc_wr;
    assign acc_rd = req_valid && req_ready && !req_write;
    assign acc_wr = req_valid && req_ready && req_write;

    assert_rd_latency_R11: assert property (@(posedge clk) disable iff (rst)
        acc_rd |=> rsp_valid);

    assert_no_stray_rsp_R11: assert property (@(posedge clk) disable iff (rst)
        !acc_rd |=> !rsp_valid);

    assert_irq_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq == '0));

    for (genvar i = 0; i < NUM_Q; i++) begin : g_chk
        assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
            int'(q_cnt_flat[i*CW +: CW]) <= DEPTH);

        assert_cnt_moves_on_access_R3: assert property (@(posedge clk) disable iff (rst)
            (q_cnt_flat[i*CW +: CW] != $past(q_cnt_flat[i*CW +: CW])) |-> $past(req_valid && req_ready));

        assert_irq_rise_push_R9: assert property (@(posedge clk) disable iff (rst)
            $rose(irq[i]) |-> $past(acc_wr));

        assert_irq_fall_pop_R9: assert property (@(posedge clk) disable iff (rst)
            $fell(irq[i]) |-> $past(acc_rd));

        assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
            ($past(q_ovf[i]) && !$past(acc_wr)) |-> q_ovf[i]);
    end
endmodule

bind msgq_top msgq_chk #(.NUM_Q(NUM_Q), .DEPTH(DEPTH), .CW(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .rsp_valid  (rsp_valid),
    .irq        (irq),
    .q_cnt_flat (q_cnt_flat),
    .q_ovf      (q_ovf)
);

// File: tb/tb_msgq_top.sv
module tb_msgq_top;
    localparam int NQ    = 8;
    localparam int DEPTH = 4;
    localparam int NP    = 2;
    localparam int AW    = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic [NQ-1:0] irq;

    int nchk = 0;
    int nfail = 0;
    bit started = 1'b0;
    bit done = 1'b0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    msgq_top #(.NUM_Q(NQ), .DEPTH(DEPTH), .NUM_PROXY(NP)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [511:0] mq  [NQ][$];
    logic [31:0]  stg [NQ][16];
    logic         movf [NQ];
    logic         exp_v;
    logic [31:0]  exp_d;
    logic [511:0] tmsg;
    int           mkind, mq_i, mw;

    always @(posedge clk) begin
        if (rst) begin
            for (int q = 0; q < NQ; q++) begin
                mq[q].delete();
                movf[q] = 1'b0;
                for (int k = 0; k < 16; k++) stg[q][k] = '0;
            end
            exp_v = 1'b0;
            exp_d = '0;
        end else begin
            exp_v = req_valid && !req_write;
            if (req_valid) begin
                mkind = 0; mq_i = 0; mw = 0;
                if (req_addr[1:0] == 2'b00) begin
                    if (!req_addr[17]) begin
                        if (req_addr[15:10] == 6'd0 && req_addr[6]) begin
                            mkind = 1; mq_i = int'(req_addr[9:7]); mw = int'(req_addr[5:2]);
                        end
                    end else if (req_addr[16:5] == 12'd0) begin
                        mkind = 2; mq_i = int'(req_addr[4:2]);
                    end
                end
                if (req_write) begin
                    if (mkind == 1) begin
                        if (mw < 15) stg[mq_i][mw] = req_wdata;
                        else begin
                            for (int k = 0; k < 15; k++) tmsg[k*32 +: 32] = stg[mq_i][k];
                            tmsg[480 +: 32] = req_wdata;
                            if (mq[mq_i].size() < DEPTH) mq[mq_i].push_back(tmsg);
                            else movf[mq_i] = 1'b1;
                            for (int k = 0; k < 16; k++) stg[mq_i][k] = '0;
                        end
                    end else if (mkind == 2) begin
                        if (req_wdata[0]) movf[mq_i] = 1'b0;
                    end
                end else begin
                    exp_d = '0;
                    if (mkind == 1) begin
                        if (mq[mq_i].size() > 0) begin
                            tmsg  = mq[mq_i][0];
                            exp_d = tmsg[mw*32 +: 32];
                            if (mw == 15) void'(mq[mq_i].pop_front());
                        end
                    end else if (mkind == 2) begin
                        exp_d = {8'h00, 12'(mq[mq_i].size()), 11'h000, movf[mq_i]};
                    end
                end
            end
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] expv, input string tag);
        nchk++;
        if (act !== expv) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (started && !rst && !done) begin
            logic [NQ-1:0] ei;
            for (int q = 0; q < NQ; q++) ei[q] = (mq[q].size() != 0);
            chk(32'(rsp_valid), 32'(exp_v), {cur_req, " model rsp_valid"});
            if (exp_v) chk(rsp_rdata, exp_d, {cur_req, " model rsp_rdata"});
            chk(32'(irq), 32'(ei), {cur_req, " model irq"});
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [AW-1:0] da(input int p, input int q, input int r);
        return {1'b0, 1'(p), 16'(q*128 + r*4)};
    endfunction
    function automatic logic [AW-1:0] sa(input int q);
        return {1'b1, 17'(q*4)};
    endfunction

    task automatic drv(input logic w, input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    endtask
    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        drv(1'b1, a, d); idle();
    endtask
    task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] expv, input string tag);
        drv(1'b0, a, 32'h0); idle();
        chk(32'(rsp_valid), 32'd1, "R11 response one cycle after read");
        chk(rsp_rdata, expv, tag);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nchk++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        started = 1'b1;
        @(negedge clk);

        cur_req = "R1";
        chk(32'(irq), 32'h0, "R1 irq after reset");
        chk(32'(req_ready), 32'd1, "R1 ready out of reset");
        rd_chk(sa(0), 32'h0, "R1 status after reset");
        cur_req = "R8";
        rd_chk(da(0, 0, 31), 32'h0, "R8 pop on empty queue");
        rd_chk(sa(0), 32'h0, "R8 count stays zero");

        cur_req = "R3";
        for (int r = 16; r < 32; r++) wr(da(0, 1, r), 32'hA100_0000 + 32'(r - 16));
        rd_chk(sa(1), 32'h0000_1000, "R3 count after push");
        rd_chk(sa(1), 32'h0000_1000, "R13 status layout");
        chk(32'(irq[1]), 32'd1, "R9 irq high with message");

        cur_req = "R5";
        rd_chk(da(1, 1, 20), 32'hA100_0004, "R2 proxy alias peek");
        rd_chk(da(0, 1, 20), 32'hA100_0004, "R5 repeat peek");
        rd_chk(sa(1), 32'h0000_1000, "R5 count unchanged by peek");

        cur_req = "R6";
        wr(da(0, 2, 18), 32'h0000_BEEF);
        wr(da(0, 2, 31), 32'h0000_0031);
        wr(da(0, 2, 31), 32'h0000_0005);
        rd_chk(da(0, 2, 17), 32'h0, "R6 unwritten word is zero");
        rd_chk(da(0, 2, 18), 32'h0000_BEEF, "R6 written word");
        rd_chk(da(0, 2, 31), 32'h0000_0031, "R4 pop first message");
        rd_chk(da(0, 2, 18), 32'h0, "R6 staging cleared after push");
        rd_chk(da(0, 2, 31), 32'h0000_0005, "R4 pop second message");

        cur_req = "R4";
        for (int k = 1; k <= 3; k++) wr(da(0, 3, 31), 32'(k));
        rd_chk(da(0, 3, 31), 32'd1, "R4 fifo order 1");
        rd_chk(da(0, 3, 31), 32'd2, "R4 fifo order 2");
        chk(32'(irq[3]), 32'd1, "R9 irq held while nonempty");
        rd_chk(da(0, 3, 31), 32'd3, "R4 fifo order 3");
        chk(32'(irq[3]), 32'd0, "R9 irq drops when empty");

        cur_req = "R7";
        for (int k = 10; k <= 14; k++) wr(da(0, 4, 31), 32'(k));
        rd_chk(sa(4), 32'h0000_4001, "R7 full count and overflow flag");
        for (int k = 10; k <= 13; k++) rd_chk(da(0, 4, 31), 32'(k), "R7 dropped push kept queue intact");
        rd_chk(sa(4), 32'h0000_0001, "R7 overflow flag sticky");
        wr(sa(4), 32'h0000_0001);
        rd_chk(sa(4), 32'h0, "R7 overflow flag cleared");
        cur_req = "R8";
        rd_chk(da(0, 4, 31), 32'h0, "R8 empty pop returns zero");
        rd_chk(sa(4), 32'h0, "R8 count stays zero");

        cur_req = "R10";
        wr(da(0, 5, 4), 32'h0000_FFFF);
        rd_chk(da(0, 5, 4), 32'h0, "R10 low register reads zero");
        wr({2'b00, 16'h8000 | 16'(5*128 + 124)}, 32'h0000_1234);
        wr(da(0, 5, 31) | 18'd2, 32'h0000_5678);
        rd_chk(sa(5), 32'h0, "R10 ignored writes left queue empty");
        rd_chk({1'b1, 17'h00100}, 32'h0, "R10 status out of range");
        rd_chk(da(0, 1, 3), 32'h0, "R10 low register with message pending");

        cur_req = "R12";
        chk(32'(irq), 32'h0000_0002, "R12 only queue 1 pending");
        rd_chk(da(1, 1, 31), 32'hA100_000F, "R4 pop through proxy 1");
        chk(32'(irq), 32'h0, "R9 all interrupts low");

        cur_req = "R11";
        drv(1'b1, da(0, 6, 31), 32'h0000_0077);
        drv(1'b0, sa(6), 32'h0);
        drv(1'b0, da(0, 6, 31), 32'h0);
        chk(rsp_rdata, 32'h0000_1000, "R3 back-to-back status after push");
        drv(1'b0, sa(6), 32'h0);
        chk(rsp_rdata, 32'h0000_0077, "R4 back-to-back pop");
        chk(32'(irq[6]), 32'd0, "R9 irq falls with pop response");
        idle();
        chk(rsp_rdata, 32'h0, "R11 back-to-back status after pop");
        idle();
        chk(32'(rsp_valid), 32'd0, "R11 no response when idle");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule